// File: doc/BRIEF.md
# Address Translator Configuration and Connect Sequencer

This block sequences start-up for one channel of a two-wire bus address translator. The channel may be in shutdown because its enable input is low or because its supply is reported in undervoltage. When the channel leaves shutdown, the block samples two quantized configuration codes. An external converter model supplies each code as a 5-bit ratio index. The block decodes the two codes into a 7-bit XOR translation value and a pass-through indication. It keeps the bus paths open until both bus segments have been seen idle. It then closes the paths and, one cycle later, reports that the channel is ready.

The sequencer has five states:

- OFF holds everything cleared.
- LATCH captures the decoded codes for one cycle.
- WAIT_IDLE waits until both segments are qualified idle.
- CONNECT closes the paths, with ready still low.
- READY keeps the paths closed and ready high.

The transitions are:

- OFF to LATCH when the channel leaves shutdown.
- LATCH to WAIT_IDLE always, after one cycle.
- WAIT_IDLE to CONNECT when both segment idle flags are set.
- CONNECT to READY always, after one cycle.
- Any state to OFF on shutdown. This transition takes priority over the others.

Every rising edge of enable passes through OFF first, so each rising edge causes the configuration to be read again.

The bus line inputs are expected to be already synchronized to `clk`. A segment counts as idle after either of two events: a STOP condition, meaning SDA rises while SCL is high, or all of its lines staying high for `IDLE_CYCLES` consecutive clocks. The default of 24000 clocks is 120 us at 200 MHz.

Top module: `xlat_cfg_seq`

## Requirements
- R1: While `rst_n` is low, and one clock after `en` goes low, `conn`, `rdy`, `pass_thru` and `xlat` are all 0.
- R2: On reset release with `en` high, and on each rising edge of `en`, `lo_code` is captured into `xlat[3:0]`. Code k gives nibble k for k = 0..15, and codes 16..31 saturate to 4'hF.
- R3: `hi_code` values 0..7 are captured as `xlat[6:4]` = k, and values 8..29 saturate to 3'b111.
- R4: A `hi_code` of 30 or 31 selects pass-through: `pass_thru` is 1 and `xlat` reads 7'h00.
- R5: Outside OFF, `pass_thru` follows `hi_code` in the same cycle. When `hi_code` returns to 0..29, `xlat` shows the captured value again without a new capture.
- R6: Changes of `lo_code` or `hi_code` (within 0..29) while enabled do not alter `xlat` until the next rising edge of `en`.
- R7: `conn` rises only after each side (master: `m_scl`/`m_sda`; slave: `s_scl`/`s_sda`) has shown either a STOP or `IDLE_CYCLES` consecutive clocks with both lines high. Holding a line low keeps `conn` at 0.
- R8: `rdy` rises exactly one clock after `conn` rises, and is never 1 while `conn` is 0.
- R9: `uv` high shuts the channel down like `en` low and clears the captured value. When `uv` falls, the codes are captured again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; a rising edge re-reads the configuration |
| uv | input | 1 | Supply undervoltage flag, high means shut down |
| lo_code | input | 5 | Ratio index for translation bits 3..0 |
| hi_code | input | 5 | Ratio index for translation bits 6..4 / pass-through |
| m_scl | input | 1 | Master-side clock line level |
| m_sda | input | 1 | Master-side data line level |
| s_scl | input | 1 | Slave-side clock line level |
| s_sda | input | 1 | Slave-side data line level |
| xlat | output | 7 | Translation value applied by XOR to the address |
| pass_thru | output | 1 | Translation bypassed |
| conn | output | 1 | Close both SCL and SDA paths |
| rdy | output | 1 | Channel configured and connected |

## Verification
The bench builds the block with `IDLE_CYCLES` set to 16. The all-high idle window is therefore short enough to observe both sides of it: a wait of twelve cycles must leave the paths open, and by twenty-two cycles they must be closed. With the short window, a STOP on the master side is also clearly faster than the timed route. The code widths stay at their defaults, so every lower code, the saturating upper codes and both pass-through codes are reachable from the vector table.

// File: rtl/xlat_cfg_pkg.sv
package xlat_cfg_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_LATCH,
        ST_WAIT_IDLE,
        ST_CONNECT,
        ST_READY
    } seq_state_t;
endpackage

// File: rtl/xlat_code_decode.sv
// Maps the two ratio indices onto translation bits and a pass-through flag.
module xlat_code_decode #(
    parameter int CODE_W   = 5,
    parameter int LO_W     = 4,
    parameter int HI_W     = 3,
    parameter int PASS_MIN = 30
) (
    input  logic [CODE_W-1:0] lo_code,
    input  logic [CODE_W-1:0] hi_code,
    output logic [LO_W-1:0]   lo_bits,
    output logic [HI_W-1:0]   hi_bits,
    output logic              pass_sel
);
    localparam int LO_MAX = (1 << LO_W) - 1;
    localparam int HI_MAX = (1 << HI_W) - 1;

    always_comb begin
        if (int'(lo_code) > LO_MAX) lo_bits = LO_W'(LO_MAX);
        else                        lo_bits = lo_code[LO_W-1:0];

        pass_sel = 1'b0;
        if (int'(hi_code) >= PASS_MIN) begin
            pass_sel = 1'b1;
            hi_bits  = '0;
        end else if (int'(hi_code) > HI_MAX) begin
            hi_bits  = HI_W'(HI_MAX);
        end else begin
            hi_bits  = hi_code[HI_W-1:0];
        end
    end
endmodule

// File: rtl/bus_side_idle.sv
// Sticky idle qualifier for one bus segment: STOP seen, or lines high long enough.
module bus_side_idle #(
    parameter int IDLE_CYCLES = 24000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic scl,
    input  logic sda,
    output logic idle
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);

    logic          scl_d, sda_d;
    logic [CW-1:0] high_cnt;
    logic          stop_seen, high_done;

    assign stop_seen = scl && scl_d && sda && !sda_d;
    assign high_done = scl && sda && (high_cnt == CW'(IDLE_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
            high_cnt <= '0;
            idle     <= 1'b0;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
            if (clr) begin
                high_cnt <= '0;
                idle     <= 1'b0;
            end else begin
                if (scl && sda) begin
                    if (high_cnt != CW'(IDLE_CYCLES)) high_cnt <= high_cnt + 1'b1;
                end else begin
                    high_cnt <= '0;
                end
                if (stop_seen || high_done) idle <= 1'b1;
            end
        end
    end

    // R7: a cleared qualifier never reports idle on the next cycle
    assert_clr_drops_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !idle);
endmodule

// File: rtl/xlat_cfg_seq.sv
module xlat_cfg_seq #(
    parameter int CODE_W      = 5,
    parameter int LO_W        = 4,
    parameter int HI_W        = 3,
    parameter int PASS_MIN    = 30,
    parameter int IDLE_CYCLES = 24000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   uv,
    input  logic [CODE_W-1:0]      lo_code,
    input  logic [CODE_W-1:0]      hi_code,
    input  logic                   m_scl,
    input  logic                   m_sda,
    input  logic                   s_scl,
    input  logic                   s_sda,
    output logic [LO_W+HI_W-1:0]   xlat,
    output logic                   pass_thru,
    output logic                   conn,
    output logic                   rdy
);
    import xlat_cfg_pkg::*;

    localparam int XW    = LO_W + HI_W;
    localparam int SIDES = 2;

    seq_state_t      state_q, state_d;
    logic [XW-1:0]   xlat_q;
    logic [LO_W-1:0] lo_bits;
    logic [HI_W-1:0] hi_bits;
    logic            pass_live;
    logic            shutdown;
    logic            idle_clr;
    logic [SIDES-1:0] side_scl, side_sda, side_idle;
    logic            both_idle;

    assign shutdown = !en || uv;
    assign idle_clr = (state_q != ST_WAIT_IDLE);
    assign side_scl = {s_scl, m_scl};
    assign side_sda = {s_sda, m_sda};
    assign both_idle = &side_idle;

    xlat_code_decode #(
        .CODE_W(CODE_W), .LO_W(LO_W), .HI_W(HI_W), .PASS_MIN(PASS_MIN)
    ) u_decode (
        .lo_code (lo_code),
        .hi_code (hi_code),
        .lo_bits (lo_bits),
        .hi_bits (hi_bits),
        .pass_sel(pass_live)
    );

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        bus_side_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (idle_clr),
            .scl  (side_scl[g]),
            .sda  (side_sda[g]),
            .idle (side_idle[g])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:       state_d = ST_LATCH;
            ST_LATCH:     state_d = ST_WAIT_IDLE;
            ST_WAIT_IDLE: if (both_idle) state_d = ST_CONNECT;
            ST_CONNECT:   state_d = ST_READY;
            ST_READY:     state_d = ST_READY;
            default:      state_d = ST_OFF;
        endcase
        if (shutdown) state_d = ST_OFF;
    end

    // State register and captured translation value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            xlat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_OFF)        xlat_q <= '0;
            else if (state_q == ST_LATCH) xlat_q <= {hi_bits, lo_bits};
        end
    end

    // Outputs
    always_comb begin
        conn      = 1'b0;
        rdy       = 1'b0;
        pass_thru = 1'b0;
        xlat      = '0;
        unique case (state_q)
            ST_OFF: ;
            ST_LATCH, ST_WAIT_IDLE: begin
                pass_thru = pass_live;
                xlat      = pass_live ? '0 : xlat_q;
            end
            ST_CONNECT: begin
                conn      = 1'b1;
                pass_thru = pass_live;
                xlat      = pass_live ? '0 : xlat_q;
            end
            ST_READY: begin
                conn      = 1'b1;
                rdy       = 1'b1;
                pass_thru = pass_live;
                xlat      = pass_live ? '0 : xlat_q;
            end
            default: ;
        endcase
    end

    assert_down_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (!conn && !rdy));
    assert_conn_needs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conn) |-> $past(both_idle));
    assert_rdy_under_conn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> conn);
    assert_rdy_after_conn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(conn));
    assert_xlat_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conn && $past(conn) && !pass_thru && !$past(pass_thru)) |-> $stable(xlat));
endmodule

// File: tb/xlat_cfg_seq_tb.sv
`timescale 1ns/1ps
module xlat_cfg_seq_tb_top;
    localparam int IDLE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1, uv = 1'b0;
    logic [4:0] lo_code = 5'd5, hi_code = 5'd3;
    logic       m_scl = 1'b1, m_sda = 1'b1, s_scl = 1'b1, s_sda = 1'b1;
    logic [6:0] xlat;
    logic       pass_thru, conn, rdy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xlat_cfg_seq #(.IDLE_CYCLES(IDLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .uv(uv),
        .lo_code(lo_code), .hi_code(hi_code),
        .m_scl(m_scl), .m_sda(m_sda), .s_scl(s_scl), .s_sda(s_sda),
        .xlat(xlat), .pass_thru(pass_thru), .conn(conn), .rdy(rdy)
    );

    // {lo_code, hi_code, expected xlat, expected pass_thru}
    localparam logic [17:0] VEC [10] = '{
        {5'd0,  5'd0,  7'h00, 1'b0},
        {5'd5,  5'd3,  7'h35, 1'b0},
        {5'd15, 5'd7,  7'h7F, 1'b0},
        {5'd1,  5'd2,  7'h21, 1'b0},
        {5'd9,  5'd20, 7'h79, 1'b0},
        {5'd20, 5'd0,  7'h0F, 1'b0},
        {5'd6,  5'd29, 7'h76, 1'b0},
        {5'd3,  5'd30, 7'h00, 1'b1},
        {5'd31, 5'd31, 7'h00, 1'b1},
        {5'd10, 5'd5,  7'h5A, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic relink(input logic [4:0] lo, input logic [4:0] hi);
        en = 1'b0;
        tick(2);
        lo_code = lo;
        hi_code = hi;
        en = 1'b1;
        tick(25);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tick(3);
        chk("R1 conn in reset", conn, 0);
        chk("R1 rdy in reset", rdy, 0);
        chk("R1 xlat in reset", xlat, 0);
        chk("R1 pass in reset", pass_thru, 0);
        rst_n = 1'b1;
        // R2: capture on reset release, R7 timed idle, R8 ready one cycle after connect
        tick(12);
        chk("R7 open before idle window", conn, 0);
        for (int i = 0; i < 20 && !conn; i++) tick(1);
        chk("R8 conn up", conn, 1);
        chk("R8 rdy lags conn", rdy, 0);
        tick(1);
        chk("R8 rdy one cycle later", rdy, 1);
        chk("R2 captured at reset release", xlat, 7'h35);

        // R2 R3 R4: vector table
        foreach (VEC[i]) begin
            relink(VEC[i][17:13], VEC[i][12:8]);
            chk("R2 R3 R4 vector xlat", xlat, VEC[i][7:1]);
            chk("R4 vector pass", pass_thru, VEC[i][0]);
            chk("R7 vector linked", rdy, 1);
        end

        // R6: code changes while enabled are ignored
        relink(5'd4, 5'd1);
        lo_code = 5'd12;
        hi_code = 5'd6;
        tick(5);
        chk("R6 ignored while enabled", xlat, 7'h14);
        en = 1'b0;
        tick(2);
        chk("R1 conn after en low", conn, 0);
        chk("R1 xlat after en low", xlat, 0);
        en = 1'b1;
        tick(25);
        chk("R6 re-read on enable rise", xlat, 7'h6C);

        // R5: live pass-through override
        hi_code = 5'd30;
        tick(1);
        chk("R5 live pass", pass_thru, 1);
        chk("R5 xlat zero in pass", xlat, 0);
        chk("R5 still connected", conn, 1);
        hi_code = 5'd6;
        tick(1);
        chk("R5 pass released", pass_thru, 0);
        chk("R5 captured value back", xlat, 7'h6C);

        // R9: undervoltage shutdown and re-capture
        uv = 1'b1;
        tick(2);
        chk("R9 uv conn", conn, 0);
        chk("R9 uv rdy", rdy, 0);
        chk("R9 uv xlat", xlat, 0);
        lo_code = 5'd2;
        hi_code = 5'd4;
        uv = 1'b0;
        tick(25);
        chk("R9 recapture after uv", xlat, 7'h42);

        // R7: master SCL held low blocks connect; STOP on master side releases it
        en = 1'b0;
        m_scl = 1'b0;
        tick(2);
        en = 1'b1;
        tick(3 * IDLE);
        chk("R7 held low stays open", conn, 0);
        m_sda = 1'b0;
        tick(1);
        m_scl = 1'b1;
        tick(1);
        chk("R7 no STOP yet", conn, 0);
        m_sda = 1'b1;
        tick(3);
        chk("R7 STOP connects", conn, 1);
        chk("R8 ready after STOP link", rdy, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule